// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Configuration Loader

This block is a master for a three-wire serial EEPROM that answers a read command with 16-bit words. When reset is released it fetches a programmable number of consecutive words, starting at word address 0. Each word is handed to the surrounding register file as a one-cycle write strobe with its address and data. A strap input can select built-in defaults instead. In that case the memory is never touched and the loader reports completion at once.

After boot the block serves single read requests through a ready/request/acknowledge handshake. The serial clock is the system clock divided by a parameter, 64 by default. Output data is launched on the falling serial edge. The memory's reply is taken on the falling edge that closes each bit period, half a period after the memory drove it on the rising edge.

The clock and data-out pins are shared with two general-purpose outputs. A small select register decides, pin by pin, which function drives each pin. Reset selects the memory function for both pins.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: `mem_sck_o` has a period of exactly DIV (64) system clocks while chip enable is high. Each period is low for its first half and high for its second. The clock stays low whenever chip enable is low.
- R2: While chip enable stays high, `mem_sdo_o` changes only in the system cycle where `mem_sck_o` falls.
- R3: A read frame keeps chip enable high for exactly 27 serial clocks. The first 11 rising edges carry a start bit 1, the opcode bits 1 then 0, and the 8-bit word address MSB first.
- R4: The loader samples `mem_sdi_i` at the end of bit periods 10 to 26 (counting from 0). It discards the first sample (the dummy 0) and assembles the next 16 samples MSB first into the returned word.
- R5: Chip enable is active high and is low during and after reset. Between two frames it stays low for at least DIV system clocks.
- R6: With `strap_int_i`=0 and `boot_words_i`=N>0, the loader reads addresses 0 to N-1 in increasing order. It gives one `cfg_we_o` pulse per word carrying that address and the word, then raises `boot_done_o`, which stays high until reset.
- R7: With `strap_int_i`=1, `boot_done_o` rises within 3 cycles of reset release. Chip enable never rises during boot and no `cfg_we_o` pulse occurs.
- R8: With `strap_int_i`=0 and `boot_words_i`=0, the loader completes boot the same way, without any frame.
- R9: `rd_ready_o` is high only after boot, while no read is in flight. A `rd_req_i` while ready reads `rd_addr_i` and ends with a one-cycle `rd_ack_o` and the word on `rd_data_o`. A `rd_req_i` while not ready is ignored.
- R10: After reset both shared pins carry the memory function. A `mux_we_i` cycle loads `mux_sel_i`: bit 0 set gives the clock pin to `gpo_i[0]`, and bit 1 set gives the data-out pin to `gpo_i[1]`.
- R11: `cfg_we_o` never pulses once `boot_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_int_i | input | 1 | 1: use built-in defaults, 0: boot from memory |
| boot_words_i | input | ADDR_W+1 | Number of words fetched at boot |
| boot_done_o | output | 1 | Boot finished, sticky until reset |
| cfg_we_o | output | 1 | Register file write strobe |
| cfg_addr_o | output | ADDR_W | Register file write address |
| cfg_data_o | output | DATA_W | Register file write data |
| rd_ready_o | output | 1 | A single read may be requested |
| rd_req_i | input | 1 | Single read request |
| rd_addr_i | input | ADDR_W | Word address of the single read |
| rd_ack_o | output | 1 | Single read complete |
| rd_data_o | output | DATA_W | Word returned by the single read |
| mux_we_i | input | 1 | Load pin select register |
| mux_sel_i | input | 2 | Pin select: bit 0 clock pin, bit 1 data-out pin |
| gpo_i | input | 2 | General-purpose output values |
| mem_ce_o | output | 1 | Memory chip enable, active high |
| mem_sck_o | output | 1 | Serial clock pin |
| mem_sdo_o | output | 1 | Serial data-out pin |
| mem_sdi_i | input | 1 | Serial data from memory |

## Verification
The engine's assertions take for granted that a new transfer is never started while one is in flight. They also take for granted that the boot word count holds steady through boot. The sequencer meets the first condition internally. The bench meets the second by changing `boot_words_i` only while reset is asserted. The edge and gap checks on the shared pins hold only while the select register keeps the memory function. For that reason the bench reprograms the multiplexer only between frames and restores it through reset.

// File: rtl/cfg_eeprom_pkg.sv
package cfg_eeprom_pkg;
  localparam logic [2:0] RD_CMD = 3'b110;  // start bit, then read opcode

  typedef enum logic [1:0] {
    E_IDLE,
    E_XFER,
    E_GAP
  } eng_state_e;

  typedef enum logic [2:0] {
    S_BOOT,
    S_BWAIT,
    S_FIN,
    S_IDLE,
    S_RWAIT
  } seq_state_e;
endpackage

// File: rtl/cfg_eeprom_engine.sv
module cfg_eeprom_engine
  import cfg_eeprom_pkg::*;
#(
  parameter int DIV    = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int PH_W  = $clog2(DIV);
  localparam int HALF  = DIV / 2;
  localparam int CMD_W = 3 + ADDR_W;
  localparam int LAST  = CMD_W + DATA_W - 1;
  localparam int BIT_W = $clog2(LAST + 1);
  localparam int LC_W  = $clog2(DIV + 1);

  eng_state_e        state_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] rx_q;
  logic [1:0]        sync_q;
  logic              ce_q, sclk_q, done_q;
  logic              wrap;

  assign wrap = (ph_q == PH_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      cmd_q   <= '0;
      rx_q    <= '0;
      sync_q  <= '0;
      ce_q    <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sync_q <= {sync_q[0], sdi_i};
      unique case (state_q)
        E_IDLE: begin
          if (start_i) begin
            state_q <= E_XFER;
            ce_q    <= 1'b1;
            sclk_q  <= 1'b0;
            ph_q    <= '0;
            bit_q   <= '0;
            cmd_q   <= {RD_CMD, addr_i};
          end
        end
        E_XFER: begin
          if (wrap) begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
            cmd_q  <= {cmd_q[CMD_W-2:0], 1'b0};
            if (bit_q >= BIT_W'(CMD_W - 1))
              rx_q <= {rx_q[DATA_W-2:0], sync_q[1]};
            if (bit_q == BIT_W'(LAST)) begin
              state_q <= E_GAP;
              ce_q    <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == PH_W'(HALF - 1)) sclk_q <= 1'b1;
          end
        end
        E_GAP: begin
          if (wrap) begin
            ph_q    <= '0;
            state_q <= E_IDLE;
            done_q  <= 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = rx_q;
  assign ce_o   = ce_q;
  assign sclk_o = sclk_q;
  assign sdo_o  = cmd_q[CMD_W-1];

  // gap monitor for the chip-enable low time between frames
  logic [LC_W-1:0] low_cnt_q;
  logic            seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      if (ce_q) low_cnt_q <= '0;
      else if (low_cnt_q != LC_W'(DIV)) low_cnt_q <= low_cnt_q + 1'b1;
      if (ce_q) seen_q <= 1'b1;
    end
  end

  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_q && $past(ce_q) && (sdo_o != $past(sdo_o))) |-> $fell(sclk_q)); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_q |-> !sclk_q); // R1
  AST_CE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ce_q) && seen_q) |-> (low_cnt_q >= LC_W'(DIV))); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == E_IDLE)); // R9
endmodule

// File: rtl/cfg_eeprom_seq.sv
module cfg_eeprom_seq
  import cfg_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_int_i,
  input  logic [ADDR_W:0]   boot_words_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_data_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              boot_done_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              rd_ready_o,
  output logic              rd_ack_o,
  output logic [DATA_W-1:0] rd_data_o
);
  seq_state_e        state_q;
  logic [ADDR_W:0]   cnt_q;
  logic [ADDR_W-1:0] addr_q, cfg_addr_q;
  logic [DATA_W-1:0] cfg_data_q, rd_data_q;
  logic              start_q, done_q, we_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_BOOT;
      cnt_q      <= '0;
      addr_q     <= '0;
      cfg_addr_q <= '0;
      cfg_data_q <= '0;
      rd_data_q  <= '0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
      we_q       <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      we_q    <= 1'b0;
      ack_q   <= 1'b0;
      unique case (state_q)
        S_BOOT: begin
          if (strap_int_i || (boot_words_i == '0)) begin
            state_q <= S_FIN;
          end else begin
            cnt_q   <= '0;
            addr_q  <= '0;
            start_q <= 1'b1;
            state_q <= S_BWAIT;
          end
        end
        S_BWAIT: begin
          if (eng_done_i) begin
            we_q       <= 1'b1;
            cfg_addr_q <= addr_q;
            cfg_data_q <= eng_data_i;
            if ((cnt_q + 1'b1) == boot_words_i) begin
              state_q <= S_FIN;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              addr_q  <= addr_q + 1'b1;
              start_q <= 1'b1;
            end
          end
        end
        S_FIN: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        S_IDLE: begin
          if (rd_req_i) begin
            addr_q  <= rd_addr_i;
            start_q <= 1'b1;
            state_q <= S_RWAIT;
          end
        end
        S_RWAIT: begin
          if (eng_done_i) begin
            ack_q     <= 1'b1;
            rd_data_q <= eng_data_i;
            state_q   <= S_IDLE;
          end
        end
        default: state_q <= S_BOOT;
      endcase
    end
  end

  assign start_o     = start_q;
  assign addr_o      = addr_q;
  assign boot_done_o = done_q;
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = cfg_addr_q;
  assign cfg_data_o  = cfg_data_q;
  assign rd_ready_o  = (state_q == S_IDLE);
  assign rd_ack_o    = ack_q;
  assign rd_data_o   = rd_data_q;

  AST_WE_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> !boot_done_o); // R11
  AST_ACK_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> boot_done_o); // R9
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> boot_done_o); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |=> !rd_ack_o); // R9
endmodule

// File: rtl/cfg_eeprom_pinmux.sv
module cfg_eeprom_pinmux #(
  parameter int NPIN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NPIN-1:0] sel_i,
  input  logic [NPIN-1:0] gpo_i,
  input  logic [NPIN-1:0] func_i,
  output logic [NPIN-1:0] pin_o
);
  logic [NPIN-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;  // memory function after reset
    else if (we_i) sel_q <= sel_i;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_o[i] = sel_q[i] ? gpo_i[i] : func_i[i];
  end

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(sel_q)); // R10
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
  parameter int DIV    = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_int_i,
  input  logic [ADDR_W:0]   boot_words_i,
  output logic              boot_done_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              rd_ready_o,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              mux_we_i,
  input  logic [1:0]        mux_sel_i,
  input  logic [1:0]        gpo_i,
  output logic              mem_ce_o,
  output logic              mem_sck_o,
  output logic              mem_sdo_o,
  input  logic              mem_sdi_i
);
  logic              eng_start, eng_done, eng_sclk, eng_sdo;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_data;
  logic [1:0]        pins;

  cfg_eeprom_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_int_i  (strap_int_i),
    .boot_words_i (boot_words_i),
    .rd_req_i     (rd_req_i),
    .rd_addr_i    (rd_addr_i),
    .eng_done_i   (eng_done),
    .eng_data_i   (eng_data),
    .start_o      (eng_start),
    .addr_o       (eng_addr),
    .boot_done_o  (boot_done_o),
    .cfg_we_o     (cfg_we_o),
    .cfg_addr_o   (cfg_addr_o),
    .cfg_data_o   (cfg_data_o),
    .rd_ready_o   (rd_ready_o),
    .rd_ack_o     (rd_ack_o),
    .rd_data_o    (rd_data_o)
  );

  cfg_eeprom_engine #(.DIV(DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .addr_i  (eng_addr),
    .done_o  (eng_done),
    .data_o  (eng_data),
    .ce_o    (mem_ce_o),
    .sclk_o  (eng_sclk),
    .sdo_o   (eng_sdo),
    .sdi_i   (mem_sdi_i)
  );

  cfg_eeprom_pinmux #(.NPIN(2)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mux_we_i),
    .sel_i  (mux_sel_i),
    .gpo_i  (gpo_i),
    .func_i ({eng_sdo, eng_sclk}),
    .pin_o  (pins)
  );

  assign mem_sck_o = pins[0];
  assign mem_sdo_o = pins[1];
endmodule

// File: tb/tb_cfg_eeprom_loader.sv
`timescale 1ns/1ps
module tb_cfg_eeprom_loader;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NRD = 6;
  // {address, expected word}
  localparam logic [23:0] RD_VEC [NRD] = '{
    24'h00_C33C, 24'hFF_3CC3, 24'hA5_6699, 24'h5A_9966, 24'h01_C23D, 24'h80_43BC};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_int = 1'b0;
  logic [AW:0] boot_words = '0;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic mux_we = 1'b0;
  logic [1:0] mux_sel = '0;
  logic [1:0] gpo = '0;
  logic sdi = 1'b1;
  logic boot_done_o, cfg_we_o, rd_ready_o, rd_ack_o, mem_ce_o, mem_sck_o, mem_sdo_o;
  logic [AW-1:0] cfg_addr_o;
  logic [DW-1:0] cfg_data_o, rd_data_o;

  always #4 clk = ~clk;

  cfg_eeprom_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_int_i(strap_int), .boot_words_i(boot_words),
    .boot_done_o(boot_done_o), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
    .cfg_data_o(cfg_data_o), .rd_ready_o(rd_ready_o), .rd_req_i(rd_req),
    .rd_addr_i(rd_addr), .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o),
    .mux_we_i(mux_we), .mux_sel_i(mux_sel), .gpo_i(gpo), .mem_ce_o(mem_ce_o),
    .mem_sck_o(mem_sck_o), .mem_sdo_o(mem_sdo_o), .mem_sdi_i(sdi));

  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'hC3, a ^ 8'h3C};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model
  int e = 0, frames = 0, bad_cmd = 0, len_bad = 0;
  logic [10:0] cmd = '0;
  logic [7:0] last_addr = '0;
  logic [7:0] frame_addr [16];
  always @(posedge mem_sck_o or negedge mem_ce_o) begin
    if (!mem_ce_o) begin
      if (e != 0 && e != 27) len_bad++;
      e = 0;
      sdi = 1'b1;
    end else begin
      if (e <= 10) begin
        cmd = {cmd[9:0], mem_sdo_o};
        if (e == 10) begin
          if (cmd[10:8] != 3'b110) bad_cmd++;
          last_addr = cmd[7:0];
          if (frames < 16) frame_addr[frames] = cmd[7:0];
          frames++;
          sdi = 1'b0;
        end
      end else if (e <= 26) begin
        sdi = mem_word(last_addr)[26-e];
      end
      e++;
    end
  end

  // port monitors
  logic p_ce = 0, p_sck = 0, p_sdo = 0;
  int sdo_bad = 0, per_bad = 0, rises = 0, idle_bad = 0, low_run = 0, gap_min = 1000000;
  int since_rise = 0, ce_cyc = 0, we_n = 0, ack_n = 0, late_we = 0;
  bit have_rise = 0, seen_fall = 0, idle_chk = 1;
  logic [AW-1:0] wa [16];
  logic [DW-1:0] wd [16];
  logic [DW-1:0] ack_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce_o && p_ce && (mem_sdo_o != p_sdo) && !(p_sck && !mem_sck_o)) sdo_bad++;
      if (mem_ce_o) begin
        ce_cyc++;
        since_rise++;
        if (mem_sck_o && !p_sck) begin
          rises++;
          if (have_rise && since_rise != 64) per_bad++;
          have_rise = 1;
          since_rise = 0;
        end
      end else begin
        have_rise = 0;
        since_rise = 0;
        if (idle_chk && mem_sck_o) idle_bad++;
        low_run++;
      end
      if (!mem_ce_o && p_ce) begin seen_fall = 1; low_run = 1; end
      if (mem_ce_o && !p_ce && seen_fall && low_run < gap_min) gap_min = low_run;
      if (cfg_we_o) begin
        if (we_n < 16) begin wa[we_n] = cfg_addr_o; wd[we_n] = cfg_data_o; end
        we_n++;
        if (boot_done_o) late_we++;
      end
      if (rd_ack_o) begin ack_n++; ack_data = rd_data_o; end
    end
    p_ce = mem_ce_o; p_sck = mem_sck_o; p_sdo = mem_sdo_o;
  end

  task automatic restart(input bit strap, input int words);
    @(negedge clk);
    rst_n = 0;
    strap_int = strap;
    boot_words = (AW+1)'(words);
    frames = 0; we_n = 0; ack_n = 0; late_we = 0; ce_cyc = 0;
    sdo_bad = 0; per_bad = 0; idle_bad = 0; rises = 0;
    seen_fall = 0; gap_min = 1000000;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !boot_done_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // boot of four words from memory
    restart(0, 4);
    check(mem_ce_o == 0, "R5 ce low in reset", mem_ce_o, 0);
    check({mem_sck_o, mem_sdo_o} == 2'b00, "R10 pins default in reset",
          {mem_sck_o, mem_sdo_o}, 0);
    check(boot_done_o == 0 && rd_ready_o == 0, "R9 not ready in reset",
          {boot_done_o, rd_ready_o}, 0);
    rst_n = 1;
    repeat (100) @(negedge clk);
    rd_addr = 8'h77; rd_req = 1;   // R9: ignored while booting
    @(negedge clk); rd_req = 0;
    wait_done(20000);
    check(boot_done_o == 1, "R6 boot done", boot_done_o, 1);
    check(we_n == 4, "R6 write count", we_n, 4);
    for (int i = 0; i < 4; i++) begin
      check(wa[i] == AW'(i), "R6 write address", wa[i], i);
      check(wd[i] == mem_word(8'(i)), "R4 boot word", wd[i], mem_word(8'(i)));
      check(frame_addr[i] == 8'(i), "R3 frame address", frame_addr[i], i);
    end
    check(frames == 4, "R9 early request ignored", frames, 4);
    check(ack_n == 0, "R9 no ack for ignored request", ack_n, 0);
    check(bad_cmd == 0, "R3 start and opcode", bad_cmd, 0);
    check(len_bad == 0, "R3 27 clocks per frame", len_bad, 0);
    check(rises == 4 * 27, "R3 clock count", rises, 108);
    check(ce_cyc == 4 * 27 * 64, "R1 ce high cycles", ce_cyc, 4 * 27 * 64);
    check(per_bad == 0, "R1 serial period", per_bad, 0);
    check(idle_bad == 0, "R1 clock low while idle", idle_bad, 0);
    check(sdo_bad == 0, "R2 data out on falling edge", sdo_bad, 0);
    check(gap_min >= 64, "R5 gap between frames", gap_min, 64);

    // single reads from the vector table
    for (int v = 0; v < NRD; v++) begin
      int a0;
      for (int i = 0; i < 100 && !rd_ready_o; i++) @(negedge clk);
      a0 = ack_n;
      rd_addr = RD_VEC[v][23:16];
      rd_req = 1;
      @(negedge clk); rd_req = 0;
      for (int i = 0; i < 3000 && ack_n == a0; i++) @(negedge clk);
      check(ack_n == a0 + 1, "R9 single ack", ack_n, a0 + 1);
      check(ack_data == RD_VEC[v][15:0], "R4 single read data", ack_data, RD_VEC[v][15:0]);
      check(last_addr == RD_VEC[v][23:16], "R3 single read address", last_addr,
            RD_VEC[v][23:16]);
    end
    check(late_we == 0 && we_n == 4, "R11 no write after done", we_n, 4);
    check(sdo_bad == 0 && per_bad == 0, "R2 edges in single reads", sdo_bad + per_bad, 0);

    // pin multiplexer
    idle_chk = 0;
    @(negedge clk);
    mux_we = 1; mux_sel = 2'b11; gpo = 2'b01;
    @(negedge clk); mux_we = 0;
    @(negedge clk);
    check({mem_sdo_o, mem_sck_o} == 2'b01, "R10 gpo on pins", {mem_sdo_o, mem_sck_o}, 1);
    gpo = 2'b10;
    @(negedge clk);
    check({mem_sdo_o, mem_sck_o} == 2'b10, "R10 gpo follows", {mem_sdo_o, mem_sck_o}, 2);
    mux_we = 1; mux_sel = 2'b01;
    @(negedge clk); mux_we = 0;
    @(negedge clk);
    check({mem_sdo_o, mem_sck_o} == 2'b00, "R10 per-pin select", {mem_sdo_o, mem_sck_o}, 0);
    gpo = 2'b11;
    @(negedge clk);
    check(mem_sck_o == 1, "R10 clock pin on gpo", mem_sck_o, 1);

    // internal strap: reset also restores mux defaults
    restart(1, 4);
    check({mem_sdo_o, mem_sck_o} == 2'b00, "R10 mux reset default", {mem_sdo_o, mem_sck_o}, 0);
    idle_chk = 1;
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(boot_done_o == 1, "R7 done quickly", boot_done_o, 1);
    repeat (200) @(negedge clk);
    check(ce_cyc == 0 && frames == 0, "R7 no memory access", ce_cyc, 0);
    check(we_n == 0, "R7 no writes", we_n, 0);

    // zero words from memory
    restart(0, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(boot_done_o == 1, "R8 done with zero words", boot_done_o, 1);
    repeat (200) @(negedge clk);
    check(ce_cyc == 0 && we_n == 0, "R8 no frame", ce_cyc + we_n, 0);

    // single word boot
    restart(0, 1);
    rst_n = 1;
    wait_done(5000);
    check(we_n == 1 && wa[0] == 0, "R6 one-word boot", we_n, 1);
    check(wd[0] == 16'hC33C, "R4 one-word data", wd[0], 16'hC33C);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule